// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits in front of an interrupt controller that accepts only rising-edge or active-high requests. It takes a bank of asynchronous interrupt lines (up to 256). Each line is synchronized and then, according to its own 3-bit trigger type, passed through, inverted or edge-detected. The result is a clean active-high level or a one-cycle rising pulse that the controller can consume without knowing the original polarity.

Every line also has an enable bit and a sticky pending flag. Software programs the enables and trigger types through a small word-addressed write/read port. It reads the pending flags and clears them by writing ones. The pending-clear path exists because changing a line's trigger type while its input is steady can flip the normalized signal and record an interrupt that never happened.

Top module: `wake_irq_normalizer`

## Requirements
- R1: After synchronous reset every enable bit is 0, every pending flag is 0, every `irq_out` bit is 0, and every trigger-type word reads back 3'b100.
- R2: Enable bits are packed 32 per word at byte address 0x10 + 4*(n/32), bit n%32; a write stores the whole word, a read returns it, and line n is active only while its bit is 1.
- R3: Line n's trigger type sits in bits [2:0] of the word at byte address 0x110 + 4*n; a read returns the last value written to those bits with bits [31:3] as zero.
- R4: Trigger type 3'b100 (level, active high) drives `irq_out[n]` equal to the input, three clock edges after the input changes.
- R5: Trigger type 3'b000 (level, active low) drives `irq_out[n]` to the inverse of the input with the same latency.
- R6: Trigger type 3'b110 (rising edge) gives a single-cycle `irq_out[n]` pulse, three edges after a 0-to-1 input change, and nothing on a 1-to-0 change.
- R7: Trigger type 3'b010 (falling edge) gives a single-cycle pulse after a 1-to-0 input change and nothing on a 0-to-1 change.
- R8: Trigger type 3'b111 (both edges) gives a single-cycle pulse after each input transition.
- R9: Every `irq_out` assertion sets line n's sticky pending flag. The flag reads at bit n%32 of the word at 0x50 + 4*(n/32). Writing that word clears exactly the flags whose data bits are 1, and zero bits leave flags untouched.
- R10: While a line is disabled its `irq_out` bit and pending flag stay 0 whatever its input does.
- R11: Changing a line's trigger type while its input is steady can set the pending flag (for example rising to falling with the input low), and that flag is cleared by the R9 write.
- R12: When a clear write and a new event on the same line land on the same clock edge, the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt lines |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | NUM_LINES | Normalized active-high or rising-pulse requests |

## Verification
Two things can fall on the same clock edge: a pending-clear write from software and a fresh normalized event on that same line. The bench provokes this by timing the clear write so that its commit edge is the edge on which a rising-edge pulse is produced. It counts three edges from the input change to place the write. It then reads the pending word and expects the flag still set, which shows that the new event wins over the clear. Type-change phantoms are provoked the same way, with a steady input and a trigger-type write, and judged by reading the pending word before and after a clear.

// File: rtl/wake_norm_pkg.sv
// Package: shared constants and types for the wakeup polarity normalizer.
// Assumes a 32-bit register word and byte addressing with word-aligned access.
package wake_norm_pkg;

    localparam int WORD_W      = 32;
    localparam int ENABLE_BASE = 32'h010;
    localparam int CLEAR_BASE  = 32'h050;
    localparam int CFG_BASE    = 32'h110;
    localparam int TRIG_W      = 3;

    typedef logic [TRIG_W-1:0] trig_t;

    // Bit meaning inside a trigger code: [2] polarity high, [1] edge mode, [0] both edges
    localparam trig_t TRIG_LVL_LO  = 3'b000;
    localparam trig_t TRIG_FALL    = 3'b010;
    localparam trig_t TRIG_LVL_HI  = 3'b100;
    localparam trig_t TRIG_RISE    = 3'b110;
    localparam trig_t TRIG_BOTH    = 3'b111;

endpackage

// File: rtl/wake_sync.sv
// Module: two-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is implied.
module wake_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: shift raw inputs through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

endmodule

// File: rtl/wake_line.sv
// Module: normalizer for one line. It applies polarity, detects edges and keeps a
// sticky pending flag. Assumes din is already synchronized to clk.
module wake_line
    import wake_norm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    input  logic  en,
    input  trig_t cfg,
    input  logic  clr,
    output logic  irq,
    output logic  pend
);

    logic norm;
    logic prev_q;
    logic edge_ev;
    logic event_now;
    logic irq_q;
    logic pend_q;

    // Purpose: fold polarity and pick edge or level behaviour from the trigger code.
    always_comb begin
        norm      = din ^ ~cfg[2];
        edge_ev   = cfg[0] ? (norm ^ prev_q) : (norm & ~prev_q);
        event_now = cfg[1] ? edge_ev : norm;
    end

    // Purpose: remember the previous normalized level and register output and pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            irq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= norm;
            irq_q  <= en & event_now;
            pend_q <= en & ((pend_q & ~clr) | event_now);
        end
    end

    assign irq  = irq_q;
    assign pend = pend_q;

    // R10: a disabled line produces neither output nor pending
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!irq_q && !pend_q));

    // R12: every emitted request is also recorded, even under a clear
    a_r12_irq_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> pend_q);

    // R9: pending holds while enabled and not cleared
    a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && en && !clr) |=> pend_q);

endmodule

// File: rtl/wake_regs.sv
// Module: register port holding the enable words and trigger codes. It produces
// per-line clear strobes and returns read data combinationally.
// Assumes word-aligned accesses; unmatched addresses read zero and ignore writes.
module wake_regs
    import wake_norm_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic [NUM_LINES-1:0]       pend_vec,
    output logic [NUM_LINES-1:0]       en_vec,
    output logic [NUM_LINES-1:0][TRIG_W-1:0] cfg_vec,
    output logic [NUM_LINES-1:0]       clr_vec
);

    localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int WIDX_W    = ADDR_W - 2;

    logic [WORD_W-1:0] en_word [NUM_WORDS];
    trig_t             cfg_q   [NUM_LINES];

    logic              aligned;
    logic [ADDR_W-1:0] en_off, clr_off, cfg_off;
    logic [WIDX_W-1:0] en_idx, clr_idx, cfg_idx;
    logic              en_hit, clr_hit, cfg_hit;

    // Purpose: decode the address into one of the three register banks.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        en_off  = bus_addr - ADDR_W'(ENABLE_BASE);
        clr_off = bus_addr - ADDR_W'(CLEAR_BASE);
        cfg_off = bus_addr - ADDR_W'(CFG_BASE);
        en_idx  = en_off[ADDR_W-1:2];
        clr_idx = clr_off[ADDR_W-1:2];
        cfg_idx = cfg_off[ADDR_W-1:2];
        en_hit  = aligned && (bus_addr >= ADDR_W'(ENABLE_BASE)) && (en_idx  < WIDX_W'(NUM_WORDS));
        clr_hit = aligned && (bus_addr >= ADDR_W'(CLEAR_BASE))  && (clr_idx < WIDX_W'(NUM_WORDS));
        cfg_hit = aligned && (bus_addr >= ADDR_W'(CFG_BASE))    && (cfg_idx < WIDX_W'(NUM_LINES));
    end

    // Purpose: store enable words; reset disables every line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) en_word[w] <= '0;
        end else if (bus_wr && en_hit) begin
            for (int w = 0; w < NUM_WORDS; w++)
                if (en_idx == WIDX_W'(w)) en_word[w] <= bus_wdata;
        end
    end

    // Purpose: store trigger codes; reset selects level active-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_LINES; n++) cfg_q[n] <= TRIG_LVL_HI;
        end else if (bus_wr && cfg_hit) begin
            for (int n = 0; n < NUM_LINES; n++)
                if (cfg_idx == WIDX_W'(n)) cfg_q[n] <= bus_wdata[TRIG_W-1:0];
        end
    end

    // Purpose: spread stored words into per-line enables, codes and clear strobes.
    always_comb begin
        for (int n = 0; n < NUM_LINES; n++) begin
            en_vec[n]  = en_word[n / WORD_W][n % WORD_W];
            cfg_vec[n] = cfg_q[n];
            clr_vec[n] = bus_wr && clr_hit && (clr_idx == WIDX_W'(n / WORD_W))
                         && bus_wdata[n % WORD_W];
        end
    end

    // Purpose: return the addressed word; pending bits appear in the clear bank.
    always_comb begin
        bus_rdata = '0;
        if (en_hit) begin
            for (int w = 0; w < NUM_WORDS; w++)
                if (en_idx == WIDX_W'(w)) bus_rdata = en_word[w];
        end else if (clr_hit) begin
            for (int n = 0; n < NUM_LINES; n++)
                if (clr_idx == WIDX_W'(n / WORD_W)) bus_rdata[n % WORD_W] = pend_vec[n];
        end else if (cfg_hit) begin
            for (int n = 0; n < NUM_LINES; n++)
                if (cfg_idx == WIDX_W'(n)) bus_rdata = WORD_W'(cfg_q[n]);
        end
    end

    // R2: a write to the first enable word lands there on the next cycle
    a_r2_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ENABLE_BASE)) |=> (en_word[0] == $past(bus_wdata)));

    // R3: a write to line 0's trigger word keeps only the low three bits
    a_r3_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CFG_BASE)) |=> (cfg_q[0] == $past(bus_wdata[TRIG_W-1:0])));

endmodule

// File: rtl/wake_irq_normalizer.sv
// Module: top of the wakeup polarity normalizer. It synchronizes the raw lines and
// runs one normalizer per line under register control.
// Assumes NUM_LINES <= 256 and ADDR_W wide enough for 0x110 + 4*NUM_LINES.
module wake_irq_normalizer
    import wake_norm_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0]             sync_vec;
    logic [NUM_LINES-1:0]             en_vec;
    logic [NUM_LINES-1:0]             clr_vec;
    logic [NUM_LINES-1:0]             pend_vec;
    logic [NUM_LINES-1:0][TRIG_W-1:0] cfg_vec;

    wake_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (sync_vec)
    );

    wake_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pend_vec (pend_vec),
        .en_vec   (en_vec),
        .cfg_vec  (cfg_vec),
        .clr_vec  (clr_vec)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        wake_line u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_vec[n]),
            .en   (en_vec[n]),
            .cfg  (cfg_vec[n]),
            .clr  (clr_vec[n]),
            .irq  (irq_out[n]),
            .pend (pend_vec[n])
        );
    end

endmodule

// File: tb/tb_wake_irq_normalizer.sv
module tb_wake_irq_normalizer;

    localparam int N  = 64;
    localparam int AW = 12;
    localparam int L  = 37;               // word 1, bit 5
    localparam int LB = L % 32;

    // {cfg[2:0], input, out after 3 edges, out one cycle later, pending, 0}
    localparam logic [7:0] VEC [0:10] = '{
        8'b100_1_1_1_1_0, 8'b100_0_0_0_1_0, 8'b000_0_1_1_1_0, 8'b000_1_0_0_1_0,
        8'b110_0_0_0_0_0, 8'b110_1_1_0_1_0, 8'b010_0_1_0_1_0, 8'b010_1_0_0_0_0,
        8'b111_0_1_0_1_0, 8'b111_1_1_0_1_0, 8'b110_1_0_0_0_0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wake_irq_normalizer #(.NUM_LINES(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; commits on the next posedge, returns at the following negedge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b100:  return "R4";
            3'b000:  return "R5";
            3'b110:  return "R6";
            3'b010:  return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  cur_cfg;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 irq_out", irq_out[31:0] | irq_out[63:32], 32'h0);
        rd(12'h010, d); check("R1 enable word0", d, 32'h0);
        rd(12'h014, d); check("R1 enable word1", d, 32'h0);
        rd(12'h110, d); check("R1 cfg line0", d, 32'h4);
        rd(12'h050, d); check("R1 pending word0", d, 32'h0);

        // R10: disabled line 6 ignores its input
        irq_in[6] = 1'b1; idle(5);
        check("R10 disabled irq", {31'b0, irq_out[6]}, 32'h0);
        rd(12'h050, d); check("R10 disabled pending", d, 32'h0);
        wr(12'h010, 32'h40); idle(1);
        check("R2 enabled line6 follows", {31'b0, irq_out[6]}, 32'h1);
        wr(12'h010, 32'h0); idle(1);
        check("R10 disable drops irq", {31'b0, irq_out[6]}, 32'h0);
        rd(12'h050, d); check("R10 disable drops pending", d, 32'h0);
        irq_in[6] = 1'b0;

        // R2 / R3: register readback
        wr(12'h014, 32'h0000_0020);
        rd(12'h014, d); check("R2 enable word1 readback", d, 32'h20);
        rd(12'h010, d); check("R2 enable word0 untouched", d, 32'h0);
        wr(AW'(12'h110 + 4*L), 32'hFFFF_FFF6);
        rd(AW'(12'h110 + 4*L), d); check("R3 cfg readback low bits", d, 32'h6);
        cur_cfg = 3'b110;
        idle(4);

        // Table walk over all trigger types (R4..R8, R9 pending)
        for (int i = 0; i < 11; i++) begin
            logic [7:0] v;
            v = VEC[i];
            if (v[7:5] != cur_cfg) begin
                wr(AW'(12'h110 + 4*L), {29'b0, v[7:5]});
                cur_cfg = v[7:5];
                idle(4);
            end
            wr(12'h054, 32'hFFFF_FFFF);
            irq_in[L] = v[4];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(tag_of(v[7:5]), {31'b0, irq_out[L]}, {31'b0, v[3]});
            @(posedge clk); @(negedge clk);
            check(tag_of(v[7:5]), {31'b0, irq_out[L]}, {31'b0, v[2]});
            rd(12'h054, d);
            check("R9 pending after vector", {31'b0, d[LB]}, {31'b0, v[1]});
        end

        // R11: phantom from a type change with a steady input
        irq_in[L] = 1'b0; idle(5);
        wr(12'h054, 32'hFFFF_FFFF);
        rd(12'h054, d); check("R11 pending clear before change", d, 32'h0);
        wr(AW'(12'h110 + 4*L), 32'h2);
        idle(1);
        rd(12'h054, d); check("R11 phantom pending", {31'b0, d[LB]}, 32'h1);
        wr(12'h054, 32'h20);
        rd(12'h054, d); check("R11 phantom cleared", d, 32'h0);

        // R12: clear write and rising event on the same edge
        wr(AW'(12'h110 + 4*L), 32'h6);
        idle(4);
        wr(12'h054, 32'hFFFF_FFFF);
        irq_in[L] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(12'h054, 32'h20);
        check("R12 pulse on collision edge", {31'b0, irq_out[L]}, 32'h1);
        rd(12'h054, d); check("R12 pending survives clear", {31'b0, d[LB]}, 32'h1);

        // R9: zero bits leave pending alone, one bits clear it
        wr(12'h054, 32'h0);
        rd(12'h054, d); check("R9 zero write keeps pending", {31'b0, d[LB]}, 32'h1);
        wr(12'h054, 32'h10);
        rd(12'h054, d); check("R9 other bit keeps pending", {31'b0, d[LB]}, 32'h1);
        wr(12'h054, 32'h20);
        rd(12'h054, d); check("R9 one bit clears pending", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule